// File: doc/BRIEF.md
# Serial Divider-Ratio Load Interface

This block is the programming port of a frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a load strobe. Bits are shifted into an 18-bit word register that sits behind a 1-bit control register. When the load strobe rises, the control bit picks the destination. A one loads the 14-bit reference-divider ratio. A zero loads the feedback-divider pair: a 6-bit swallow count and a 12-bit main count. Either latch can be rewritten alone, and the other keeps its value.

The three serial wires are asynchronous to the block's system clock. Each one passes through a synchronizer and an edge detector. A shift happens one system clock after the synchronized serial clock rises. A load happens one system clock after the synchronized strobe rises. The ratio outputs are registers. Each latch also drives a flag that is low after reset and goes high once that latch has been loaded.

Top module: `serial_ratio_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts one bit. The `ser_data` level moves into the control position, and the bit that was in the control position moves into word bit 17. Words are sent least significant bit first, and the control bit is sent last.
- R2: A feedback word is 19 bits long. It is sent as swallow bits 0..5, then main bits 0..11, then the control bit 0. After the strobe, `swallow_cnt` and `main_cnt` hold those values.
- R3: A reference word is 15 bits long. It is sent as ratio bits 0..13, then the control bit 1. After the strobe, `ref_ratio` holds the value, so a ratio of 5 is sent as bit0=1, bit1=0, bit2=1 and all other bits 0.
- R4: A load changes only the latch that the control bit selects. The other latch keeps its contents.
- R5: A load happens only on a rising edge of `ser_le`. Holding `ser_le` high while more bits are shifted changes no output.
- R6: While `ser_le` stays low, the ratio outputs hold their values whatever happens on `ser_clk` and `ser_data`.
- R7: `ref_loaded` and `fb_loaded` are 0 after reset. Each goes to 1 on the first load of its latch and stays at 1 until the next reset.
- R8: Reset sets all ratio outputs to 0. After any reset, each divider can be rewritten alone.
- R9: If more bits are shifted than the word needs, only the last 19 bits count. Earlier bits fall off the far end of the word register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| ref_ratio | output | 14 | Reference-divider ratio |
| swallow_cnt | output | 6 | Swallow count of the feedback divider |
| main_cnt | output | 12 | Main count of the feedback divider |
| ref_loaded | output | 1 | Reference latch has been loaded since reset |
| fb_loaded | output | 1 | Feedback latch has been loaded since reset |

## Verification
The bench sends words of both lengths, including all-ones values. It sends a reference word after a feedback word, so that stale low bits remain in the word register; a design that takes the reference field from the low end would load garbage. It shifts extra leading bits and checks that only the last 19 count. It also holds the strobe high during further shifting, where a level-sensitive load would overwrite the latch. Finally, it shifts bits with the strobe low and rewrites one divider alone, where a wrong select decode would disturb the other latch.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Field widths of the two ratio latches.
  localparam int unsigned SWALLOW_W = 6;
  localparam int unsigned MAIN_W    = 12;
  localparam int unsigned REF_W     = 14;
  localparam int unsigned SYNC_N    = 2;

  // Index of each serial wire in the synchronizer bus.
  typedef enum logic [1:0] {
    PIN_SCLK = 2'd0,
    PIN_SDAT = 2'd1,
    PIN_LOAD = 2'd2
  } pin_idx_e;
endpackage

// File: rtl/sld_rst_sync.sv
module sld_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level = stage_q[STAGES-1];
  assign rise  = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sld_shifter.sv
module sld_shifter #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_q,
  output logic              ctrl_q
);
  logic [WORD_W-1:0] word_d;
  logic              ctrl_d;

  // The newest bit takes the control slot; the old control bit enters the top of the word.
  always_comb begin
    word_d = word_q;
    ctrl_d = ctrl_q;
    if (shift_en) begin
      word_d = {ctrl_q, word_q[WORD_W-1:1]};
      ctrl_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ctrl_q <= 1'b0;
    end else begin
      word_q <= word_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/sld_ratio_bank.sv
module sld_ratio_bank #(
  parameter int unsigned SW_W  = 6,
  parameter int unsigned MN_W  = 12,
  parameter int unsigned RF_W  = 14,
  localparam int unsigned WD_W = SW_W + MN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            sel_ref,
  input  logic [WD_W-1:0] word,
  output logic [RF_W-1:0] ref_q,
  output logic [SW_W-1:0] sw_q,
  output logic [MN_W-1:0] mn_q,
  output logic            ref_done_q,
  output logic            fb_done_q
);
  logic            ref_en;
  logic            fb_en;
  logic [RF_W-1:0] ref_d;
  logic [SW_W-1:0] sw_d;
  logic [MN_W-1:0] mn_d;
  logic            ref_done_d;
  logic            fb_done_d;

  assign ref_en = load & sel_ref;
  assign fb_en  = load & ~sel_ref;

  // A short reference word ends at the top of the word register.
  always_comb begin
    ref_d      = ref_en ? word[WD_W-1 -: RF_W] : ref_q;
    sw_d       = fb_en  ? word[SW_W-1:0]       : sw_q;
    mn_d       = fb_en  ? word[SW_W +: MN_W]   : mn_q;
    ref_done_d = ref_done_q | ref_en;
    fb_done_d  = fb_done_q  | fb_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      sw_q       <= '0;
      mn_q       <= '0;
      ref_done_q <= 1'b0;
      fb_done_q  <= 1'b0;
    end else begin
      ref_q      <= ref_d;
      sw_q       <= sw_d;
      mn_q       <= mn_d;
      ref_done_q <= ref_done_d;
      fb_done_q  <= fb_done_d;
    end
  end
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader
  import sld_pkg::*;
#(
  parameter int unsigned A_W = SWALLOW_W,
  parameter int unsigned N_W = MAIN_W,
  parameter int unsigned R_W = REF_W,
  parameter int unsigned SYNC_STAGES = SYNC_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [R_W-1:0] ref_ratio,
  output logic [A_W-1:0] swallow_cnt,
  output logic [N_W-1:0] main_cnt,
  output logic           ref_loaded,
  output logic           fb_loaded
);
  localparam int unsigned WORD_W = A_W + N_W;

  logic             rst_sync_n;
  logic [2:0]       pin_lvl;
  logic [2:0]       pin_rise;
  logic             shift_rise;
  logic             data_lvl;
  logic             le_rise;
  logic [WORD_W-1:0] word_q;
  logic             ctrl_q;

  sld_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sld_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({ser_le, ser_data, ser_clk}),
    .level (pin_lvl),
    .rise  (pin_rise)
  );

  assign shift_rise = pin_rise[PIN_SCLK];
  assign data_lvl   = pin_lvl[PIN_SDAT];
  assign le_rise    = pin_rise[PIN_LOAD];

  sld_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_rise),
    .bit_in   (data_lvl),
    .word_q   (word_q),
    .ctrl_q   (ctrl_q)
  );

  sld_ratio_bank #(.SW_W(A_W), .MN_W(N_W), .RF_W(R_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (le_rise),
    .sel_ref    (ctrl_q),
    .word       (word_q),
    .ref_q      (ref_ratio),
    .sw_q       (swallow_cnt),
    .mn_q       (main_cnt),
    .ref_done_q (ref_loaded),
    .fb_done_q  (fb_loaded)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12,
  parameter int unsigned R_W = 14,
  localparam int unsigned WORD_W = A_W + N_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_rise,
  input logic              data_lvl,
  input logic              le_rise,
  input logic              ctrl_q,
  input logic [WORD_W-1:0] word_q,
  input logic [R_W-1:0]    ref_ratio,
  input logic [A_W-1:0]    swallow_cnt,
  input logic [N_W-1:0]    main_cnt,
  input logic              ref_loaded,
  input logic              fb_loaded
);
  // R1: the sampled data bit lands in the control slot
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> ctrl_q == $past(data_lvl));

  // R1: the old control bit moves to the top of the word
  p_shift_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> word_q[WORD_W-1] == $past(ctrl_q));

  // R3: reference latch takes the top field of the word
  p_ref_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && ctrl_q) |=> ref_ratio == $past(word_q[WORD_W-1 -: R_W]));

  // R2: feedback latch takes both fields of the word
  p_fb_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !ctrl_q) |=> {main_cnt, swallow_cnt} == $past(word_q));

  // R4: a reference load leaves the feedback pair alone
  p_ref_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && ctrl_q) |=> $stable(swallow_cnt) && $stable(main_cnt));

  // R4: a feedback load leaves the reference alone
  p_fb_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !ctrl_q) |=> $stable(ref_ratio));

  // R5 / R6: no strobe edge, no change
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ref_ratio) && $stable(swallow_cnt) && $stable(main_cnt));

  // R7: flags are sticky
  p_ref_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_loaded |=> ref_loaded);
  p_fb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_loaded |=> fb_loaded);

  // R7: flag set by a load of its own latch
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> (ctrl_q ? ref_loaded : fb_loaded) || !$past(rst_n));
endmodule

bind serial_ratio_loader sld_checker #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .shift_rise  (shift_rise),
  .data_lvl    (data_lvl),
  .le_rise     (le_rise),
  .ctrl_q      (ctrl_q),
  .word_q      (word_q),
  .ref_ratio   (ref_ratio),
  .swallow_cnt (swallow_cnt),
  .main_cnt    (main_cnt),
  .ref_loaded  (ref_loaded),
  .fb_loaded   (fb_loaded)
);

// File: tb/test_serial_ratio_loader.sv
`timescale 1ns/1ps
module test_serial_ratio_loader;
  logic        clk;
  logic        rst_n;
  logic        ser_clk;
  logic        ser_data;
  logic        ser_le;
  logic [13:0] ref_ratio;
  logic [5:0]  swallow_cnt;
  logic [11:0] main_cnt;
  logic        ref_loaded;
  logic        fb_loaded;

  int n_chk;
  int n_bad;

  logic [13:0] exp_ref;
  logic [5:0]  exp_a;
  logic [11:0] exp_n;
  logic        exp_rl;
  logic        exp_fl;

  serial_ratio_loader i_serial_ratio_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .ser_le      (ser_le),
    .ref_ratio   (ref_ratio),
    .swallow_cnt (swallow_cnt),
    .main_cnt    (main_cnt),
    .ref_loaded  (ref_loaded),
    .fb_loaded   (fb_loaded)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "ref_ratio", int'(ref_ratio), int'(exp_ref));
    chk(req, "swallow_cnt", int'(swallow_cnt), int'(exp_a));
    chk(req, "main_cnt", int'(main_cnt), int'(exp_n));
    chk(req, "ref_loaded", int'(ref_loaded), int'(exp_rl));
    chk(req, "fb_loaded", int'(fb_loaded), int'(exp_fl));
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clks(4);
    ser_clk = 1'b1;
    wait_clks(4);
    ser_clk = 1'b0;
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_clks(6);
    ser_le = 1'b0;
    wait_clks(4);
  endtask

  // LSB first, control bit last
  task automatic shift_fb(input logic [5:0] a, input logic [11:0] n);
    for (int i = 0; i < 6; i++) send_bit(a[i]);
    for (int i = 0; i < 12; i++) send_bit(n[i]);
    send_bit(1'b0);
  endtask

  task automatic shift_ref(input logic [13:0] r);
    for (int i = 0; i < 14; i++) send_bit(r[i]);
    send_bit(1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    exp_ref = '0; exp_a = '0; exp_n = '0; exp_rl = 1'b0; exp_fl = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_all("R8 R7 reset");
  endtask

  task automatic t_ref_five();
    shift_ref(14'd5);
    pulse_le();
    exp_ref = 14'd5; exp_rl = 1'b1;
    chk_all("R3 R4 ref=5");
  endtask

  task automatic t_fb_load();
    shift_fb(6'd17, 12'd300);
    pulse_le();
    exp_a = 6'd17; exp_n = 12'd300; exp_fl = 1'b1;
    chk_all("R2 R4 fb 17/300");
  endtask

  task automatic t_max_values();
    shift_ref(14'h3FFF);
    pulse_le();
    exp_ref = 14'h3FFF;
    chk_all("R3 ref max");
    shift_fb(6'h3F, 12'hFFF);
    pulse_le();
    exp_a = 6'h3F; exp_n = 12'hFFF;
    chk_all("R2 fb max");
  endtask

  task automatic t_no_strobe();
    shift_ref(14'd1234);
    for (int i = 0; i < 7; i++) send_bit(logic'(i[0]));
    wait_clks(6);
    chk_all("R6 shifting without strobe");
  endtask

  task automatic t_ref_after_fb();
    // the low word bits still hold feedback leftovers
    shift_fb(6'h2A, 12'h555);
    pulse_le();
    exp_a = 6'h2A; exp_n = 12'h555;
    shift_ref(14'h1234);
    pulse_le();
    exp_ref = 14'h1234;
    chk_all("R3 R4 ref after fb");
  endtask

  task automatic t_extra_bits();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    shift_fb(6'd3, 12'd77);
    pulse_le();
    exp_a = 6'd3; exp_n = 12'd77;
    chk_all("R9 leading bits dropped");
  endtask

  task automatic t_le_held();
    shift_ref(14'd900);
    ser_le = 1'b1;
    wait_clks(6);
    exp_ref = 14'd900;
    chk_all("R5 first edge loads");
    shift_ref(14'd42);
    wait_clks(6);
    chk_all("R5 held strobe no reload");
    ser_le = 1'b0;
    wait_clks(6);
    chk_all("R5 strobe fall no load");
    pulse_le();
    exp_ref = 14'd42;
    chk_all("R5 next edge loads");
  endtask

  task automatic t_reset_rewrite();
    do_reset();
    chk_all("R8 R7 reset after use");
    shift_fb(6'd9, 12'd5);
    pulse_le();
    exp_a = 6'd9; exp_n = 12'd5; exp_fl = 1'b1;
    chk_all("R8 R7 single rewrite");
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_le = 1'b0;
    exp_ref = '0; exp_a = '0; exp_n = '0; exp_rl = 1'b0; exp_fl = 1'b0;
    t_reset_state();
    t_ref_five();
    t_fb_load();
    t_max_values();
    t_no_strobe();
    t_ref_after_fb();
    t_extra_bits();
    t_le_held();
    t_reset_rewrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule